// File: doc/BRIEF.md
# Timing Error Replacement Unit

This function unit sits on the data transport network of a transport-triggered processor. It collects the raw error outputs of many late-arrival detector flops that guard critical paths in the approximate arithmetic units. It merges them into a single sticky error flag that software can read. Writing an operand to the trigger port starts an operation, and the result appears one cycle later.

Software uses the unit to keep or discard a computed word. It first loads a fallback word with the set-safe operation. After a block of approximate arithmetic, a replace operation returns either the computed word or the fallback word, depending on whether any detector fired, and clears the flag in the same cycle. A check operation only reports the flag and clears it. Error sampling is synchronous: a detector level present at a rising clock edge is recorded. An error that arrives while a clearing operation runs is kept for the next query.

Top module: `ter_unit`

## Requirements
- R1: A high level on any single bit of `err_pulse_i` at a rising edge sets the error flag. Every bit is merged by an OR tree of parameterised fan-in, so every source has the same effect.
- R2: The flag stays set through idle cycles, set-safe operations and reserved operations. Only a check or a replace clears it.
- R3: Opcode 2'b00 (check) returns 1 zero-extended to `DATA_W` bits when the flag is set and 0 otherwise, then clears the flag.
- R4: Opcode 2'b01 (replace) returns the stored safe word when the flag is set and `operand_i` unchanged otherwise, then clears the flag.
- R5: Opcode 2'b10 (set-safe) stores `operand_i` as the safe word, returns 0 and leaves the flag unchanged.
- R6: Opcode 2'b11 is reserved. It returns 0 and changes neither the flag nor the safe word.
- R7: Every operation takes one cycle. `result_o` and `result_valid_o` update at the edge that samples `trig_i` high, and `result_valid_o` is low after any edge where `trig_i` is low.
- R8: An error sampled at edge k is reported by an operation triggered at edge k+2 or later. An operation triggered at edge k+1 neither reports it nor clears it, so the error is not lost.
- R9: Asynchronous active-low reset clears the flag, sets the safe word to zero and drives `result_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_pulse_i | input | N_SRC | Raw detector outputs, one bit per guarded path |
| trig_i | input | 1 | Operand write to the trigger port; starts an operation |
| opcode_i | input | 2 | Operation select (check, replace, set-safe, reserved) |
| operand_i | input | DATA_W | Operand transported with the trigger |
| result_o | output | DATA_W | Status word or data word of the last operation |
| result_valid_o | output | 1 | High for the one cycle after a trigger |

## Verification
The flag and the safe word are not visible at the ports, so a wrong internal state shows up only in the result of the next clearing operation. A flag that is lost, stuck high or cleared by the wrong operation shows as a wrong check value or a wrongly substituted word one cycle after the next trigger. A corrupted safe word only appears when a replace runs with the flag set. For this reason the sweeps pair every error stimulus and every set-safe with a replace or check that follows. The sweeps also place the clearing operation exactly one edge and two edges after the error, to pin down the capture latency.

// File: rtl/ter_pkg.sv
package ter_pkg;
  typedef enum logic [1:0] {
    OP_CHECK    = 2'b00,
    OP_REPLACE  = 2'b01,
    OP_SET_SAFE = 2'b10,
    OP_RSVD     = 2'b11
  } ter_op_e;

  function automatic int unsigned tree_levels(int unsigned n, int unsigned fan);
    int unsigned l;
    int unsigned c;
    l = 0;
    c = n;
    while (c > 1) begin
      c = (c + fan - 1) / fan;
      l++;
    end
    return l;
  endfunction
endpackage

// File: rtl/ter_or_tree.sv
module ter_or_tree #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned FAN_IN = 4
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);
  localparam int unsigned LEVELS = ter_pkg::tree_levels(N_SRC, FAN_IN);

  logic [N_SRC-1:0] lvl [LEVELS+1];

  always_comb begin
    for (int l = 0; l <= LEVELS; l++) lvl[l] = '0;
    lvl[0] = src_i;
    for (int l = 0; l < LEVELS; l++) begin
      for (int j = 0; j < N_SRC; j++) begin
        for (int k = 0; k < FAN_IN; k++) begin
          if (j * FAN_IN + k < N_SRC) lvl[l+1][j] = lvl[l+1][j] | lvl[l][j*FAN_IN+k];
        end
      end
    end
  end

  assign any_o = lvl[LEVELS][0];
endmodule

// File: rtl/ter_err_flag.sv
module ter_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic clear_i,
  output logic err_q_o,
  output logic flag_o
);
  logic err_q, flag_q;

  // capture stage keeps the combined error out of the flag's clear path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_i;
  end

  // a pending error wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~clear_i) | err_q;
  end

  assign err_q_o = err_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/ter_op_exec.sv
module ter_op_exec #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  ter_pkg::ter_op_e  op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              flag_i,
  output logic              clear_o,
  output logic [DATA_W-1:0] safe_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  import ter_pkg::*;

  logic [DATA_W-1:0] safe_q, res_d, res_q;
  logic              load_safe, valid_q;

  always_comb begin
    res_d     = '0;
    clear_o   = 1'b0;
    load_safe = 1'b0;
    if (trig_i) begin
      unique case (op_i)
        OP_CHECK: begin
          res_d   = {{(DATA_W-1){1'b0}}, flag_i};
          clear_o = 1'b1;
        end
        OP_REPLACE: begin
          res_d   = flag_i ? safe_q : operand_i;
          clear_o = 1'b1;
        end
        OP_SET_SAFE: load_safe = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        safe_q <= '0;
    else if (load_safe) safe_q <= operand_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= trig_i;
      if (trig_i) res_q <= res_d;
    end
  end

  assign safe_o   = safe_q;
  assign result_o = res_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/ter_unit.sv
module ter_unit #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned FAN_IN = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  err_pulse_i,
  input  logic              trig_i,
  input  logic [1:0]        opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  import ter_pkg::*;

  logic             err_any, err_seen, err_flag, flag_clear;
  logic [DATA_W-1:0] safe_val;
  ter_op_e          op;

  assign op = ter_op_e'(opcode_i);

  ter_or_tree #(.N_SRC(N_SRC), .FAN_IN(FAN_IN)) i_or_tree (
    .src_i (err_pulse_i),
    .any_o (err_any)
  );

  ter_err_flag i_err_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_any),
    .clear_i (flag_clear),
    .err_q_o (err_seen),
    .flag_o  (err_flag)
  );

  ter_op_exec #(.DATA_W(DATA_W)) i_op_exec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .op_i      (op),
    .operand_i (operand_i),
    .flag_i    (err_flag),
    .clear_o   (flag_clear),
    .safe_o    (safe_val),
    .result_o  (result_o),
    .valid_o   (result_valid_o)
  );
endmodule

// File: rtl/ter_unit_chk.sv
module ter_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic [1:0]        opcode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic              err_seen,
  input logic              err_flag,
  input logic [DATA_W-1:0] safe_val
);
  logic clr_op;
  assign clr_op = trig_i && (opcode_i == 2'b00 || opcode_i == 2'b01);

  // R1
  capture_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_seen |=> err_flag);

  // R2
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag && !clr_op |=> err_flag);

  // R3
  check_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && opcode_i == 2'b00 |=> result_o == {{(DATA_W-1){1'b0}}, $past(err_flag)});

  // R4
  replace_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && opcode_i == 2'b01 && err_flag |=> result_o == $past(safe_val));

  // R4
  replace_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && opcode_i == 2'b01 && !err_flag |=> result_o == $past(operand_i));

  // R5
  set_safe_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && opcode_i == 2'b10 |=> safe_val == $past(operand_i) && result_o == '0);

  // R6
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && opcode_i == 2'b11 |=> $stable(safe_val) && result_o == '0);

  // R7
  valid_after_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> result_valid_o);

  // R7
  valid_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> !result_valid_o);

  // R8
  clear_without_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_op && !err_seen |=> !err_flag);
endmodule

bind ter_unit ter_unit_chk #(.DATA_W(DATA_W)) i_ter_unit_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .trig_i         (trig_i),
  .opcode_i       (opcode_i),
  .operand_i      (operand_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .err_seen       (err_seen),
  .err_flag       (err_flag),
  .safe_val       (safe_val)
);

// File: tb/test_ter_unit.sv
`timescale 1ns/1ps
module test_ter_unit;
  localparam int N_SRC  = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  err = '0;
  logic              trig = 1'b0;
  logic [1:0]        opc = 2'b00;
  logic [DATA_W-1:0] opnd = '0;
  logic [DATA_W-1:0] res;
  logic              vld;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ter_unit #(.N_SRC(N_SRC), .FAN_IN(4), .DATA_W(DATA_W)) i_ter_unit (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .err_pulse_i    (err),
    .trig_i         (trig),
    .opcode_i       (opc),
    .operand_i      (opnd),
    .result_o       (res),
    .result_valid_o (vld)
  );

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [N_SRC-1:0] v);
    err = v;
    @(negedge clk);
    err = '0;
  endtask

  task automatic op(logic [1:0] o, logic [DATA_W-1:0] d, output logic [DATA_W-1:0] r);
    trig = 1'b1;
    opc  = o;
    opnd = d;
    @(negedge clk);
    trig = 1'b0;
    r = res;
    total++;
    if (vld !== 1'b1) begin
      bad++;
      $display("FAIL R7: actual=%b expected=1", vld);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] safe_m;
    idle(3);
    chk("R9 valid in reset", {31'b0, vld}, 0);
    chk("R9 result in reset", res, 0);
    rst_n = 1'b1;
    idle(1);

    // R9: flag clear and safe word zero after reset
    op(2'b00, 0, r); chk("R9 check after reset", r, 0);
    pulse(16'h0001); idle(1);
    op(2'b01, 32'hdead_beef, r); chk("R9 safe zero after reset", r, 0);
    idle(1); chk("R7 valid drops", {31'b0, vld}, 0);

    safe_m = 32'h5a5a_0001;
    op(2'b10, safe_m, r); chk("R5 set-safe result", r, 0);

    // R1/R3: each source alone, check then re-check
    for (int s = 0; s < N_SRC; s++) begin
      pulse(N_SRC'(1) << s); idle(1);
      op(2'b00, 32'hffff_ffff, r); chk($sformatf("R1 R3 src %0d", s), r, 1);
      op(2'b00, 0, r); chk("R3 cleared", r, 0);
    end

    // R4: replace with and without error across data patterns
    for (int i = 0; i < 32; i++) begin
      logic [DATA_W-1:0] d;
      d = 32'h1357_9bdf ^ (32'h1 << i) ^ (i * 32'h0101_0101);
      op(2'b01, d, r); chk("R4 keep operand", r, d);
      pulse(N_SRC'(i * 7 + 1)); idle(1);
      op(2'b01, d, r); chk("R4 substitute safe", r, safe_m);
      op(2'b01, d, r); chk("R4 flag cleared", r, d);
    end

    // R2: flag survives idle, set-safe, reserved; R5 does not clear
    pulse('1); idle(5);
    op(2'b10, 32'h0bad_cafe, r); safe_m = 32'h0bad_cafe;
    op(2'b11, 32'h1111_2222, r); chk("R6 reserved result", r, 0);
    idle(3);
    op(2'b01, 32'h7777_7777, r); chk("R2 R5 R6 flag kept, safe updated", r, safe_m);

    // R6: reserved does not alter safe word
    op(2'b11, 32'h9999_9999, r);
    pulse(16'h8000); idle(1);
    op(2'b01, 32'h4, r); chk("R6 safe unchanged", r, safe_m);

    // R8: clear one edge after error does not lose it
    pulse(16'h0100);
    op(2'b00, 0, r); chk("R8 not yet reported", r, 0);
    op(2'b00, 0, r); chk("R8 error kept", r, 1);
    pulse(16'h0020);
    op(2'b01, 32'hc0de, r); chk("R8 replace keeps operand", r, 32'hc0de);
    op(2'b01, 32'hc0de, r); chk("R8 replace after late error", r, safe_m);
    op(2'b00, 0, r); chk("R8 cleared afterwards", r, 0);

    // R7: back-to-back triggers keep valid high, idle drops it
    op(2'b00, 0, r);
    op(2'b00, 0, r);
    idle(1); chk("R7 valid low when idle", {31'b0, vld}, 0);

    // R9: reset mid-run restores flag and safe word
    pulse('1); idle(1);
    rst_n = 1'b0; idle(1);
    chk("R9 valid after reset", {31'b0, vld}, 0);
    rst_n = 1'b1; idle(1);
    op(2'b00, 0, r); chk("R9 flag cleared by reset", r, 0);
    pulse(16'h0004); idle(1);
    op(2'b01, 32'h1234, r); chk("R9 safe zero by reset", r, 0);

    finished = 1;
    summary();
  end
endmodule